// File: doc/BRIEF.md
# Two-Plane Blinking Digit Store

This block keeps the character codes for a multiplexed LED display in two banks, plane 0 and plane 1, and decides from which bank the digit currently being scanned is taken. When blinking is on, the bank choice follows a blink phase bit. A counter toggles that bit after a fixed number of multiplex clock-enable pulses, so the display flips between the two banks without further software writes. Putting a character in one bank and the blank code in the other makes that character flash.

A single write port reaches the digit cells of both banks and a control register. The control register has four stored bits: run/shutdown, blink rate, blink enable and intensity mode. It also has two action bits that are never stored. One restarts the blink timing and the other fills both banks with the blank code. A read-only bit reports the blink phase. The scan logic outside the block presents a digit index and gets back the 8-bit code to pass on to the font and driver stages. The digit index is sampled combinationally.

Top module: `blink_ctrl`

## Requirements
- R1: Reset is synchronous and active-low. After reset the control readback `cfg_rdata` is 0x00 and `shutdown` is 1. Every digit cell in both planes holds the blank code 0x20.
- R2: A write with `wr_addr[ADDR_W-1]`=1 loads `wr_data` into the digit cell given by `wr_addr[DIG_W-1:0]` in the plane given by `wr_addr[DIG_W]`.
- R3: While the blink enable bit (control bit 3) is 0, `digit_data` shows the plane 0 cell of `scan_digit`.
- R4: While the blink enable bit is 1, `digit_data` shows the `scan_digit` cell of the plane equal to the current phase.
- R5: While running, the phase toggles on every FAST_TICKS-th `mux_tick` pulse when the rate bit (control bit 2) is 1. It toggles on every 2*FAST_TICKS-th pulse when the rate bit is 0.
- R6: A control write (`wr_addr`=0) with bit 4 set clears the tick count and the phase. Bit 4 always reads back as 0.
- R7: A control write with bit 5 set puts 0x20 into every cell of both planes on that same clock edge. Bit 5 always reads back as 0.
- R8: `cfg_rdata[7]` is the blink phase. Writing bit 7 has no effect.
- R9: While the run bit (control bit 0) is 0, `digit_data` is 0x00 and the phase and tick count hold their values.
- R10: Control bits 0, 2, 3 and 6 are stored by a control write and read back at the same positions. Bit 6 is also driven on `intensity_indiv`. Bits 1, 4 and 5 read as 0.
- R11: A write to any address with the top bit clear other than 0 changes neither the control register nor any digit cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mux_tick | input | 1 | Multiplex clock enable, one pulse per blink timing tick |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address: digit cell or control register |
| wr_data | input | 8 | Write data |
| scan_digit | input | DIG_W | Index of the digit being scanned |
| digit_data | output | 8 | Code of the scanned digit from the selected plane, 0 in shutdown |
| cfg_rdata | output | 8 | Control register readback including the phase bit |
| shutdown | output | 1 | High while the run bit is clear |
| intensity_indiv | output | 1 | Per-digit intensity mode selected |

## Verification
The assertions take for granted that `mux_tick` is a single-cycle enable sampled on the clock. They also assume that a control write and a digit write never happen in the same cycle, because a single address selects exactly one target. The stimulus drives one address per cycle and changes every input on the falling edge. Most of the random control writes keep the restart and clear bits low, so the phase has time to advance through complete blink periods between restarts. The scan index is drawn from the legal digit range.

// File: rtl/blink_ctrl_pkg.sv
// Package: shared constants for the two-plane blink controller.
// Assumes 8-bit digit codes; bit positions are decoded by software.
package blink_ctrl_pkg;
    localparam int          CODE_W      = 8;
    localparam int          CFG_RUN     = 0;
    localparam int          CFG_FAST    = 2;
    localparam int          CFG_BLINK   = 3;
    localparam int          CFG_RESTART = 4;
    localparam int          CFG_CLEAR   = 5;
    localparam int          CFG_INDIV   = 6;
    localparam int          CFG_PHASE   = 7;
    localparam logic [7:0]  BLANK_CODE  = 8'h20;
endpackage

// File: rtl/blink_digit_planes.sv
// Two banks of digit cells built as individual flops so that a clear
// reaches every cell on one edge. Assumes NUM_DIGITS is a power of two.
module blink_digit_planes
    import blink_ctrl_pkg::*;
#(
    parameter int NUM_DIGITS = 16,
    parameter int DIG_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_plane,
    input  logic [DIG_W-1:0]  wr_digit,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              clear,
    input  logic              rd_plane,
    input  logic [DIG_W-1:0]  rd_digit,
    output logic [CODE_W-1:0] rd_data
);
    logic [CODE_W-1:0] cells [2][NUM_DIGITS];

    for (genvar p = 0; p < 2; p++) begin : g_plane
        for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
            logic [CODE_W-1:0] cell_q;
            logic              hit;

            assign hit = wr_en && (wr_plane == 1'(p)) && (wr_digit == DIG_W'(d));

            // One digit cell: blank on reset or clear, else load on address hit.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cell_q <= BLANK_CODE;
                else if (clear)
                    cell_q <= BLANK_CODE;
                else if (hit)
                    cell_q <= wr_data;
            end

            assign cells[p][d] = cell_q;
        end
    end

    // Read mux towards the scan stage.
    always_comb rd_data = cells[rd_plane][rd_digit];
endmodule

// File: rtl/blink_timer.sv
// Blink phase generator: counts tick pulses while running and toggles the
// phase every FAST_TICKS (fast) or 2*FAST_TICKS (slow) pulses.
// Assumes tick is a one-cycle enable.
module blink_timer #(
    parameter int FAST_TICKS = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic fast,
    input  logic restart,
    output logic phase
);
    localparam int SLOW_TICKS = 2 * FAST_TICKS;
    localparam int CNT_W      = (SLOW_TICKS > 1) ? $clog2(SLOW_TICKS) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    // Terminal count for the selected rate.
    always_comb last_cnt = fast ? CNT_W'(FAST_TICKS - 1) : CNT_W'(SLOW_TICKS - 1);

    // Tick counter and phase flop; restart wins, shutdown holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (restart) begin
            cnt_q <= '0;
            phase <= 1'b0;
        end else if (run && tick) begin
            if (cnt_q >= last_cnt) begin
                cnt_q <= '0;
                phase <= ~phase;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/blink_cfg_reg.sv
// Control register: stores run, rate, blink enable and intensity mode;
// turns the restart and clear bits into single-cycle pulses, never stored.
module blink_cfg_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic d_run,
    input  logic d_fast,
    input  logic d_blink,
    input  logic d_indiv,
    input  logic d_restart,
    input  logic d_clear,
    output logic run,
    output logic fast,
    output logic blink_en,
    output logic indiv,
    output logic restart,
    output logic clear
);
    // Persistent bits; reset leaves the display shut down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            fast     <= 1'b0;
            blink_en <= 1'b0;
            indiv    <= 1'b0;
        end else if (wr) begin
            run      <= d_run;
            fast     <= d_fast;
            blink_en <= d_blink;
            indiv    <= d_indiv;
        end
    end

    // Transient action pulses, valid in the write cycle only.
    always_comb begin
        restart = wr && d_restart;
        clear   = wr && d_clear;
    end
endmodule

// File: rtl/blink_ctrl.sv
// Top: two-plane digit store with blink phase selection and control register.
// Address map: top bit set = digit cell {plane, digit}; all zero = control.
module blink_ctrl
    import blink_ctrl_pkg::*;
#(
    parameter  int NUM_DIGITS = 16,
    parameter  int FAST_TICKS = 2_000_000,
    localparam int DIG_W      = $clog2(NUM_DIGITS),
    localparam int ADDR_W     = DIG_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mux_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [DIG_W-1:0]  scan_digit,
    output logic [7:0]        digit_data,
    output logic [7:0]        cfg_rdata,
    output logic              shutdown,
    output logic              intensity_indiv
);
    logic       cfg_wr, dig_wr;
    logic       run, fast, blink_en, indiv, restart, clear, phase;
    logic [7:0] plane_data;

    // Address decode.
    always_comb begin
        cfg_wr = wr_en && (wr_addr == '0);
        dig_wr = wr_en && wr_addr[ADDR_W-1];
    end

    blink_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .d_run     (wr_data[CFG_RUN]),
        .d_fast    (wr_data[CFG_FAST]),
        .d_blink   (wr_data[CFG_BLINK]),
        .d_indiv   (wr_data[CFG_INDIV]),
        .d_restart (wr_data[CFG_RESTART]),
        .d_clear   (wr_data[CFG_CLEAR]),
        .run       (run),
        .fast      (fast),
        .blink_en  (blink_en),
        .indiv     (indiv),
        .restart   (restart),
        .clear     (clear)
    );

    blink_timer #(.FAST_TICKS(FAST_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (mux_tick),
        .run     (run),
        .fast    (fast),
        .restart (restart),
        .phase   (phase)
    );

    blink_digit_planes #(.NUM_DIGITS(NUM_DIGITS), .DIG_W(DIG_W)) u_planes (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dig_wr),
        .wr_plane (wr_addr[DIG_W]),
        .wr_digit (wr_addr[DIG_W-1:0]),
        .wr_data  (wr_data),
        .clear    (clear),
        .rd_plane (blink_en & phase),
        .rd_digit (scan_digit),
        .rd_data  (plane_data)
    );

    // Output gating and control readback assembly.
    always_comb begin
        digit_data            = run ? plane_data : 8'h00;
        cfg_rdata             = '0;
        cfg_rdata[CFG_RUN]    = run;
        cfg_rdata[CFG_FAST]   = fast;
        cfg_rdata[CFG_BLINK]  = blink_en;
        cfg_rdata[CFG_INDIV]  = indiv;
        cfg_rdata[CFG_PHASE]  = phase;
        shutdown              = ~run;
        intensity_indiv       = indiv;
    end
endmodule

// File: rtl/blink_ctrl_checker.sv
// Checker: temporal properties of the blink controller, bound to the top.
// Assumes control writes are decoded outside and passed in as cfg_wr.
module blink_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       cfg_wr,
    input logic       restart_bit,
    input logic       clear_bit,
    input logic       phase,
    input logic       shutdown,
    input logic [7:0] digit_data
);
    // R6: a restart write leaves the phase at zero.
    assert_restart_zeroes_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && restart_bit) |=> !phase);

    // R5: the phase only moves on a tick pulse.
    assert_phase_moves_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(cfg_wr && restart_bit)) |=> $stable(phase));

    // R9: shutdown freezes the phase.
    assert_phase_frozen_in_shutdown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && !(cfg_wr && restart_bit)) |=> $stable(phase));

    // R7: after a clear every scanned digit is blank (unless shut down).
    assert_clear_blanks_digits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && clear_bit) |=> (shutdown || digit_data == 8'h20));
endmodule

bind blink_ctrl blink_ctrl_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (mux_tick),
    .cfg_wr      (wr_en && (wr_addr == '0)),
    .restart_bit (wr_data[4]),
    .clear_bit   (wr_data[5]),
    .phase       (cfg_rdata[7]),
    .shutdown    (shutdown),
    .digit_data  (digit_data)
);

// File: tb/blink_ctrl_test.sv
module blink_ctrl_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int ND = 16;
    localparam int FT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mux_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] scan_digit = '0;
    logic [7:0] digit_data, cfg_rdata;
    logic       shutdown, intensity_indiv;

    always #2.5 clk = ~clk;

    blink_ctrl #(.NUM_DIGITS(ND), .FAST_TICKS(FT)) uut (
        .clk(clk), .rst_n(rst_n), .mux_tick(mux_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .scan_digit(scan_digit),
        .digit_data(digit_data), .cfg_rdata(cfg_rdata),
        .shutdown(shutdown), .intensity_indiv(intensity_indiv)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] m_plane [2][ND];
    bit m_run, m_fast, m_blink, m_indiv, m_phase;
    int m_cnt;

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_cfg();
        return {m_phase, m_indiv, 2'b00, m_blink, m_fast, 1'b0, m_run};
    endfunction

    function automatic logic [7:0] exp_digit(input int d);
        if (!m_run) return 8'h00;
        return m_plane[m_blink & m_phase][d];
    endfunction

    // Model of one clock edge from the inputs currently applied (R2, R5-R8, R11).
    task automatic model_edge();
        bit cw = wr_en && (wr_addr == 6'd0);
        int last = (m_fast ? FT : 2 * FT) - 1;
        if (cw && wr_data[4]) begin
            m_cnt = 0; m_phase = 1'b0;
        end else if (m_run && mux_tick) begin
            if (m_cnt >= last) begin m_cnt = 0; m_phase = !m_phase; end
            else m_cnt++;
        end
        if (cw) begin
            m_run = wr_data[0]; m_fast = wr_data[2];
            m_blink = wr_data[3]; m_indiv = wr_data[6];
            if (wr_data[5])
                for (int p = 0; p < 2; p++)
                    for (int d = 0; d < ND; d++) m_plane[p][d] = 8'h20;
        end
        if (wr_en && wr_addr[5]) m_plane[wr_addr[4]][wr_addr[3:0]] = wr_data;
    endtask

    task automatic step(input bit tk, input bit we, input logic [5:0] a,
                        input logic [7:0] d, input logic [3:0] sc);
        @(negedge clk);
        mux_tick = tk; wr_en = we; wr_addr = a; wr_data = d; scan_digit = sc;
        @(posedge clk);
        model_edge();
        #1;
        chk(!m_run ? "R9 digit" : (m_blink ? "R4 digit" : "R3 digit"),
            digit_data, exp_digit(int'(sc)));
        chk("R10 cfg", cfg_rdata, exp_cfg());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        for (int p = 0; p < 2; p++)
            for (int d = 0; d < ND; d++) m_plane[p][d] = 8'h20;
        m_cnt = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 cfg", cfg_rdata, 8'h00);
        chk("R1 digit", digit_data, 8'h00);
        chk("R1 shutdown", {7'd0, shutdown}, 8'h01);
        @(negedge clk);
        rst_n = 1'b1;

        step(0, 1, 6'd0, 8'h01, 4'd5);
        chk("R1 blank", digit_data, 8'h20);

        step(0, 1, 6'b100011, 8'h5A, 4'd3);
        step(0, 1, 6'b110011, 8'hA5, 4'd3);
        chk("R2 plane0", digit_data, 8'h5A);

        step(0, 1, 6'h01, 8'h00, 4'd3);
        chk("R11 cfg", cfg_rdata, 8'h01);
        chk("R11 digit", digit_data, 8'h5A);

        step(0, 1, 6'd0, 8'h1D, 4'd3);
        chk("R6 restart", cfg_rdata, 8'h0D);
        step(0, 1, 6'd0, 8'h8D, 4'd3);
        chk("R8 phase write", cfg_rdata, 8'h0D);
        for (int i = 0; i < FT - 1; i++) step(1, 0, 6'h01, 8'h00, 4'd3);
        chk("R5 fast before", cfg_rdata, 8'h0D);
        step(1, 0, 6'h01, 8'h00, 4'd3);
        chk("R5 fast toggle", cfg_rdata, 8'h8D);
        chk("R4 plane1", digit_data, 8'hA5);

        step(0, 1, 6'd0, 8'h19, 4'd3);
        for (int i = 0; i < 2 * FT - 1; i++) step(1, 0, 6'h01, 8'h00, 4'd3);
        chk("R5 slow before", cfg_rdata, 8'h09);
        step(1, 0, 6'h01, 8'h00, 4'd3);
        chk("R5 slow toggle", cfg_rdata, 8'h89);

        step(0, 1, 6'd0, 8'h08, 4'd3);
        for (int i = 0; i < 3 * FT; i++) step(1, 0, 6'h01, 8'h00, 4'd3);
        chk("R9 hold phase", cfg_rdata, 8'h88);
        chk("R9 output off", digit_data, 8'h00);

        step(0, 1, 6'd0, 8'h21, 4'd3);
        chk("R7 plane0", digit_data, 8'h20);
        chk("R7 not stored", cfg_rdata, {m_phase, 7'h01});
        step(0, 1, 6'd0, 8'h0D, 4'd3);
        for (int i = 0; i < 4 * FT && !m_phase; i++) step(1, 0, 6'h01, 8'h00, 4'd3);
        chk("R7 plane1", digit_data, 8'h20);

        for (int i = 0; i < 4000; i++) begin
            int op = $urandom_range(0, 99);
            logic [3:0] sc = 4'($urandom_range(0, ND - 1));
            logic [7:0] d = 8'($urandom);
            if (op < 55) step(1, 0, 6'h01, 8'h00, sc);
            else if (op < 80) step(0, 1, {2'b10, 4'($urandom)} | {1'b0, 1'($urandom), 4'b0}, d, sc);
            else if (op < 92) begin
                if ($urandom_range(0, 9) != 0) d[5:4] = 2'b00;
                d[0] = ($urandom_range(0, 4) != 0);
                step(1'($urandom), 1, 6'd0, d, sc);
            end else step(1'($urandom), 1, 6'($urandom_range(1, 31)), d, sc);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule